// File: doc/BRIEF.md
# Multi-mode PWM/capture timer

This block is a single timer subsystem whose counter hardware is set up by software in one of three ways. It can act as two independent 8-bit pulse-width generators, one on each output pin. It can act as one 16-bit pulse-width generator. It can also run as a free-running 16-bit counter that timestamps edges on two capture pins. In every setup, an 8-bit prescaler slows the counting rate relative to the system clock.

Software controls the block through a small word-wide register bus. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. The register offsets are: 0 control, 1 prescaler, 2 period, 3 duty, 4 capture 0, 5 capture 1, 6 flags, 7 live counter. In the control register, bits [1:0] select the mode: 0 = dual 8-bit PWM, 1 = 16-bit PWM, 2 = capture, 3 = stopped. Bit 2 selects the active edge for capture pin 0 and bit 3 does the same for pin 1 (0 = rising, 1 = falling). In dual 8-bit mode, the low byte of the period, duty and counter registers belongs to channel 0 and the high byte belongs to channel 1.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset the mode is stopped (3), both PWM pins and both interrupt outputs are low, and the counter and capture registers read 0.
- R2: With prescaler value N, the counter advances once every N+1 clocks; right after a mode change the counter reads 0 and first steps after N+1 clocks.
- R3: In 16-bit PWM mode (1), the counter runs 0..PERIOD and restarts. `pwm_o[0]` is high exactly while counter < DUTY, and `pwm_o[1]` stays low.
- R4: In dual 8-bit mode (0), byte 0 of period/duty/counter drives `pwm_o[0]` and byte 1 drives `pwm_o[1]`. Each byte counts 0..its own period and compares against its own duty, independently of the other.
- R5: A duty of 0 holds the pin low, and a duty above the period holds the pin high.
- R6: Period and duty writes are buffered and take effect only when the counter restarts, so the running pulse is never cut short.
- R7: In capture mode (2), a selected edge on `cap_i[k]` stores the counter into capture register k and raises `irq_o[k]`. With prescaler 0, the stored value is the counter value read in the cycle the pin changed, plus 2, and the flag appears 3 clocks after the change.
- R8: The edge not selected by control bit 2+k leaves capture register k and its flag unchanged.
- R9: Writing 1 to bit k of the flags register clears flag k. Writing 0 leaves it set. `irq_o` shows the flags.
- R10: A control write that changes the mode clears the counter and the prescaler and loads the buffered period and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cap_i | input | 2 | Capture pins |
| pwm_o | output | 2 | PWM pins |
| irq_o | output | 2 | Capture flags |

## Verification
A corrupted counter or prescaler state shows up on the PWM pins within one output period. In capture mode it also shows up directly on the live counter register in the next read. A wrong active period or duty shows up only after the next restart, because of buffering, so checks follow pins across period boundaries. A wrong edge-detector state appears as a missing flag, a spurious flag or an off-by-cycle capture value three clocks after a pin change.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [1:0] {
    MD_DUAL8 = 2'd0,
    MD_PWM16 = 2'd1,
    MD_CAPT  = 2'd2,
    MD_STOP  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_PRESC = 3'd1;
  localparam logic [2:0] A_PER   = 3'd2;
  localparam logic [2:0] A_DUTY  = 3'd3;
  localparam logic [2:0] A_CAP0  = 3'd4;
  localparam logic [2:0] A_CAP1  = 3'd5;
  localparam logic [2:0] A_FLAG  = 3'd6;
  localparam logic [2:0] A_CNT   = 3'd7;
endpackage

// File: rtl/pwmcap_presc.sv
module pwmcap_presc #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic          tick
);
  localparam logic [PW-1:0] P_ONE = 1;

  logic [PW-1:0] pc_q, pc_d;

  assign tick = run && !clr && (pc_q == div);

  always_comb begin
    pc_d = pc_q;
    if (clr || !run)        pc_d = '0;
    else if (pc_q == div)   pc_d = '0;
    else                    pc_d = pc_q + P_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pwmcap_count.sv
module pwmcap_count
  import pwmcap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] per_sh,
  input  logic [CW-1:0] duty_sh,
  output logic [CW-1:0] cnt_o,
  output logic [1:0]    pwm_o
);
  localparam int HW = CW / 2;
  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [CW-1:0] C_ONE = 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_a_q, per_a_d;
  logic [CW-1:0] duty_a_q, duty_a_d;

  always_comb begin
    cnt_d    = cnt_q;
    per_a_d  = per_a_q;
    duty_a_d = duty_a_q;
    if (clr || mode == MD_STOP) begin
      cnt_d    = '0;
      per_a_d  = per_sh;
      duty_a_d = duty_sh;
    end else if (tick) begin
      case (mode)
        MD_PWM16: begin
          if (cnt_q == per_a_q) begin
            cnt_d    = '0;
            per_a_d  = per_sh;
            duty_a_d = duty_sh;
          end else begin
            cnt_d = cnt_q + C_ONE;
          end
        end
        MD_DUAL8: begin
          for (int h = 0; h < 2; h++) begin
            if (cnt_q[h*HW +: HW] == per_a_q[h*HW +: HW]) begin
              cnt_d[h*HW +: HW]    = '0;
              per_a_d[h*HW +: HW]  = per_sh[h*HW +: HW];
              duty_a_d[h*HW +: HW] = duty_sh[h*HW +: HW];
            end else begin
              cnt_d[h*HW +: HW] = cnt_q[h*HW +: HW] + H_ONE;
            end
          end
        end
        default: cnt_d = cnt_q + C_ONE;
      endcase
    end
  end

  always_comb begin
    pwm_o = '0;
    case (mode)
      MD_PWM16: pwm_o[0] = (cnt_q < duty_a_q);
      MD_DUAL8: begin
        for (int h = 0; h < 2; h++)
          pwm_o[h] = (cnt_q[h*HW +: HW] < duty_a_q[h*HW +: HW]);
      end
      default: pwm_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_a_q  <= '0;
      duty_a_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      per_a_q  <= per_a_d;
      duty_a_q <= duty_a_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmcap_capch.sv
module pwmcap_capch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fall_sel,
  input  logic          pin,
  input  logic [CW-1:0] cnt,
  input  logic          w1c,
  output logic [CW-1:0] cap_o,
  output logic          flag_o
);
  logic          s1_q, s2_q, prev_q;
  logic          hit;
  logic [CW-1:0] cap_q, cap_d;
  logic          flag_q, flag_d;

  assign hit = en && (fall_sel ? (prev_q && !s2_q) : (s2_q && !prev_q));

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (w1c) flag_d = 1'b0;
    if (hit) begin
      cap_d  = cnt;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pwmcap_timer.sv
module pwmcap_timer
  import pwmcap_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [1:0]    cap_i,
  output logic [1:0]    pwm_o,
  output logic [1:0]    irq_o
);
  tmr_mode_e     mode_q, mode_d;
  logic [1:0]    esel_q, esel_d;
  logic [PW-1:0] presc_q, presc_d;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] duty_q, duty_d;

  logic          mode_chg;
  logic          tick;
  logic [CW-1:0] cnt;
  logic [1:0]    flags;
  logic [1:0]    w1c;
  logic [CW-1:0] cap_v [2];

  assign mode_chg = wr_en && (addr == A_CTRL) && (tmr_mode_e'(wdata[1:0]) != mode_q);

  always_comb begin
    mode_d  = mode_q;
    esel_d  = esel_q;
    presc_d = presc_q;
    per_d   = per_q;
    duty_d  = duty_q;
    if (wr_en) begin
      case (addr)
        A_CTRL: begin
          mode_d = tmr_mode_e'(wdata[1:0]);
          esel_d = wdata[3:2];
        end
        A_PRESC: presc_d = wdata[PW-1:0];
        A_PER:   per_d   = wdata;
        A_DUTY:  duty_d  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_STOP;
      esel_q  <= '0;
      presc_q <= '0;
      per_q   <= '0;
      duty_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      esel_q  <= esel_d;
      presc_q <= presc_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
    end
  end

  pwmcap_presc #(.PW(PW)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (mode_q != MD_STOP),
    .clr  (mode_chg),
    .div  (presc_q),
    .tick (tick)
  );

  pwmcap_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .clr    (mode_chg),
    .tick   (tick),
    .per_sh (per_q),
    .duty_sh(duty_q),
    .cnt_o  (cnt),
    .pwm_o  (pwm_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cap
    assign w1c[g] = wr_en && (addr == A_FLAG) && wdata[g];
    pwmcap_capch #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode_q == MD_CAPT),
      .fall_sel(esel_q[g]),
      .pin     (cap_i[g]),
      .cnt     (cnt),
      .w1c     (w1c[g]),
      .cap_o   (cap_v[g]),
      .flag_o  (flags[g])
    );
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(CW-4){1'b0}}, esel_q, mode_q};
      A_PRESC: rdata = {{(CW-PW){1'b0}}, presc_q};
      A_PER:   rdata = per_q;
      A_DUTY:  rdata = duty_q;
      A_CAP0:  rdata = cap_v[0];
      A_CAP1:  rdata = cap_v[1];
      A_FLAG:  rdata = {{(CW-2){1'b0}}, flags};
      default: rdata = cnt;
    endcase
  end

  assign irq_o = flags;
endmodule

// File: rtl/pwmcap_timer_chk.sv
module pwmcap_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [1:0]    wlo,
  input logic [1:0]    mode,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [1:0]    pwm,
  input logic [1:0]    flags
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == 3'd0);

  a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (cnt == '0 && pwm == 2'b00));

  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> $stable(cnt));

  a_r3_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !pwm[1]);

  a_r10_clear_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wlo != mode) |=> (cnt == '0));

  a_r9_flag0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(wr_en && addr == 3'd6 && wlo[0])) |=> flags[0]);

  a_r9_flag1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(wr_en && addr == 3'd6 && wlo[1])) |=> flags[1]);

  a_r7_flag_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) || $rose(flags[1])) |-> ($past(mode) == 2'd2));
endmodule

bind pwmcap_timer pwmcap_timer_chk #(.CW(CW)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .wr_en(wr_en),
  .addr (addr),
  .wlo  (wdata[1:0]),
  .mode (mode_q),
  .tick (tick),
  .cnt  (cnt),
  .pwm  (pwm_o),
  .flags(flags)
);

// File: tb/pwmcap_timer_tb.sv
`timescale 1ns/1ps
module pwmcap_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  cap_i;
  logic [1:0]  pwm_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwmcap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_i(cap_i), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 pwm", pwm_o, 0);
    chk("R1 irq", irq_o, 0);
    rd(3'd7, v); chk("R1 count", v, 0);
    rd(3'd4, v); chk("R1 cap0", v, 0);
    rd(3'd0, v); chk("R1 mode", v & 3, 3);
  endtask

  task automatic t_pwm16();
    int ok0, ok1;
    wr(3'd0, 16'd3); wr(3'd1, 16'd0); wr(3'd2, 16'd9); wr(3'd3, 16'd3);
    wr(3'd0, 16'd1);
    ok0 = 1; ok1 = 1;
    for (int i = 0; i < 30; i++) begin
      int d;
      d = (i >= 10) ? 7 : 3;
      if (pwm_o[0] != ((i % 10) < d)) begin
        ok0 = 0;
        $display("FAIL R3/R6 cycle %0d actual=%0d expected=%0d", i, pwm_o[0], (i % 10) < d);
      end
      if (pwm_o[1] != 1'b0) ok1 = 0;
      if (i == 2) wr(3'd3, 16'd7);   // R6: mid-period duty change
      else @(negedge clk);
    end
    chk("R3 16-bit waveform with R6 buffered duty", ok0, 1);
    chk("R3 pin1 low", ok1, 1);
  endtask

  task automatic t_dual8();
    int ok;
    wr(3'd0, 16'd3); wr(3'd2, 16'h0704); wr(3'd3, 16'h0502);
    wr(3'd0, 16'd0);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      if (pwm_o[0] != ((i % 5) < 2) || pwm_o[1] != ((i % 8) < 5)) begin
        ok = 0;
        $display("FAIL R4 cycle %0d actual=%0d expected=%0d", i, pwm_o,
                 {((i % 8) < 5), ((i % 5) < 2)});
      end
      @(negedge clk);
    end
    chk("R4 dual channels", ok, 1);
  endtask

  task automatic t_extremes();
    int lo, hi;
    wr(3'd0, 16'd3); wr(3'd2, 16'h0303); wr(3'd3, 16'hFF00);
    wr(3'd0, 16'd0);
    lo = 1; hi = 1;
    for (int i = 0; i < 12; i++) begin
      if (pwm_o[0] != 1'b0) lo = 0;
      if (pwm_o[1] != 1'b1) hi = 0;
      @(negedge clk);
    end
    chk("R5 duty zero low", lo, 1);
    chk("R5 duty above period high", hi, 1);
  endtask

  task automatic t_presc_clear();
    int v;
    wr(3'd0, 16'd3); wr(3'd1, 16'd9); wr(3'd2, 16'd100); wr(3'd0, 16'd1);
    repeat (25) @(negedge clk);
    rd(3'd7, v); chk("R2 count with prescaler 9 after 25", v, 2);
    wr(3'd1, 16'd3);
    wr(3'd0, 16'd2);   // mode change 1 -> 2
    rd(3'd7, v); chk("R10 counter cleared", v, 0);
    for (int i = 0; i < 16; i++) begin
      rd(3'd7, v);
      if (v != i / 4) $display("FAIL R2 cycle %0d actual=%0d expected=%0d", i, v, i / 4);
      if (i == 15) chk("R2 prescaler 3 step", v, 3);
      @(negedge clk);
    end
  endtask

  task automatic t_capture();
    int c, v;
    wr(3'd0, 16'd3); wr(3'd1, 16'd0); wr(3'd0, 16'h000A);
    repeat (5) @(negedge clk);
    cap_i[1] = 1'b1;              // rising on a falling-selected channel
    repeat (4) @(negedge clk);
    chk("R8 ch1 rising ignored", irq_o[1], 0);
    rd(3'd5, v); chk("R8 cap1 unchanged", v, 0);
    @(negedge clk);
    rd(3'd7, c);
    cap_i[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 flag not yet", irq_o[0], 0);
    @(negedge clk);
    chk("R7 ch0 flag", irq_o[0], 1);
    rd(3'd4, v); chk("R7 cap0 value", v, c + 2);
    @(negedge clk);
    cap_i[0] = 1'b0;              // falling on a rising-selected channel
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R8 cap0 kept on falling", v, c + 2);
    rd(3'd7, c);
    cap_i[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 ch1 flag", irq_o[1], 1);
    rd(3'd5, v); chk("R7 cap1 value", v, c + 2);
    wr(3'd6, 16'd0);
    chk("R9 write zero keeps flags", irq_o, 3);
    wr(3'd6, 16'd1);
    chk("R9 clear ch0", irq_o, 2);
    rd(3'd6, v); chk("R9 flag register", v, 2);
    wr(3'd6, 16'd2);
    chk("R9 clear ch1", irq_o, 0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; cap_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pwm16();
    t_dual8();
    t_extremes();
    t_presc_clear();
    t_capture();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule